// File: doc/BRIEF.md
# Repeating Send Sequencer

This block decides how many times a send instruction sitting in the on-deck slot of a dock gets executed. It owns the inner repeat counter. The counter can hold a finite value from zero up to a configured maximum, or a sticky "forever" value. An upstream stage presents one on-deck instruction at a time, together with a small opcode. The sequencer answers in the same cycle. It raises `fire` for each execution of a send and raises `done` when the instruction may leave the on-deck slot.

A send fires only in a cycle where both downstream slots, data and token, report empty. It always fires at least once. After each execution the counter is tested. If the count was zero, the sequence ends. Otherwise the count steps down by one and the send fires again. Forever stays forever. A counter preloaded with N therefore gives N+1 executions.

Two non-send instructions also go through the block. The load instruction sets the counter from a literal, from the forever code, or from the low bits of the data latch. The read-out instruction merges the counter into the low bits of the data latch. An abort input clears the counter and ends a running send. Predicates and flags are handled elsewhere.

Top module: `send_sequencer`

## Requirements
- R1: After reset the counter is zero and `fire`, `done` and `dataWrite` are low while `instValid` is low. A send presented after reset fires exactly once, with `done` in the same cycle as that firing.
- R2: `fire` is high only in a cycle where `instValid` is high, `instOp` is 01 (send), and both `dataSuccEmpty` and `tokenSuccEmpty` are high.
- R3: With the counter holding a finite N, a send fires N+1 times. Each firing with a nonzero count lowers the count by one. `done` coincides with the firing made at count zero.
- R4: When the counter holds the forever code (all ones, `2**CNT_W-1`), a send keeps firing and `done` stays low. Firing leaves the code unchanged.
- R5: `abortReq` clears the counter to zero at the next edge. It takes priority over a load in the same cycle. During a send it raises `done` in that cycle. A firing that coincides with the abort still occurs; otherwise no firing happens.
- R6: The load instruction (`instOp` 10) picks its source with `setSrc`. 00 loads `setLiteral`, clamped to `MAX_COUNT`. 01 loads the forever code. 10 or 11 loads `dataIn[CNT_W-1:0]`: all ones becomes forever, and any other value is clamped to `MAX_COUNT`.
- R7: The read-out instruction (`instOp` 11) raises `dataWrite` for the cycle it is presented. `dataOut[CNT_W-1:0]` then equals the counter, and the upper bits of `dataOut` equal those of `dataIn`.
- R8: Any instruction other than a send (`instOp` 00, 10, 11) gets `done` in the cycle it is presented and never fires. Opcodes 00 and 11 leave the counter unchanged.
- R9: A send whose downstream slots are not both empty, with no abort, neither fires nor completes, and the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | An instruction occupies the on-deck slot |
| instOp | input | 2 | 00 other, 01 send, 10 load counter, 11 read counter |
| setSrc | input | 2 | Load source: 00 literal, 01 forever, 1x data latch |
| setLiteral | input | CNT_W-1 | Literal count for a load |
| dataIn | input | DATA_W | Current data latch contents |
| dataSuccEmpty | input | 1 | Downstream data slot is empty |
| tokenSuccEmpty | input | 1 | Downstream token slot is empty |
| abortReq | input | 1 | Clear the counter and end the running send |
| fire | output | 1 | One execution of the on-deck send this cycle |
| done | output | 1 | The on-deck instruction completes this cycle |
| dataWrite | output | 1 | Write `dataOut` into the data latch |
| dataOut | output | DATA_W | Data latch value with the counter merged into its low bits |

## Verification
The assertions assume only that every input is at a known level after reset. They rely on nothing about instruction order, because the counter is the block's only state. The upstream stage is still meant to hold an instruction until `done`. The randomized phase draws every input anew each cycle, including opcode switches in the middle of a send, which stays within that assumption. Aborts are drawn rarely, so that finite sequences usually run to their natural end. Directed sequences pin down clamping, the forever code, stalls, and aborts both with and without a coinciding firing.

// File: rtl/sendseq_pkg.sv
package sendseq_pkg;

  typedef enum logic [1:0] {
    OP_OTHER      = 2'b00,
    OP_SEND       = 2'b01,
    OP_SET_INNER  = 2'b10,
    OP_TAKE_INNER = 2'b11
  } instOp_e;

  typedef enum logic [1:0] {
    SRC_LITERAL  = 2'b00,
    SRC_FOREVER  = 2'b01,
    SRC_DATA     = 2'b10,
    SRC_DATA_ALT = 2'b11
  } countSrc_e;

  // strobes from control to the counter datapath
  typedef struct packed {
    logic stepDown;
    logic clearCount;
    logic loadCount;
  } cntStrobe_t;

endpackage

// File: rtl/sendseq_ctrl.sv
module sendseq_ctrl
  import sendseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       instValid,
  input  logic [1:0] instOp,
  input  logic       dataSuccEmpty,
  input  logic       tokenSuccEmpty,
  input  logic       abortReq,
  input  logic       countIsZero,
  output logic       fire,
  output logic       done,
  output logic       takeWrite,
  output cntStrobe_t strobe
);

  instOp_e opCode;
  logic    isSend;
  logic    slotsFree;

  assign opCode    = instOp_e'(instOp);
  assign isSend    = instValid && (opCode == OP_SEND);
  assign slotsFree = dataSuccEmpty && tokenSuccEmpty;

  always_comb begin
    fire      = isSend && slotsFree;
    done      = instValid && (!isSend || abortReq || (fire && countIsZero));
    takeWrite = instValid && (opCode == OP_TAKE_INNER);
    strobe.clearCount = abortReq;
    strobe.loadCount  = instValid && (opCode == OP_SET_INNER) && !abortReq;
    strobe.stepDown   = fire && !abortReq;
  end

  // a stalled send must neither execute nor retire
  assert_stall_holds_R9: assert property (@(posedge clk) disable iff (!rstN)
    (isSend && !slotsFree && !abortReq) |-> (!fire && !done));

  // non-send instructions retire at once and never execute
  assert_nonsend_retires_R8: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && !isSend) |-> (done && !fire));

endmodule

// File: rtl/sendseq_dp.sv
module sendseq_dp
  import sendseq_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int MAX_COUNT = 12,
  parameter int CNT_W     = $clog2(MAX_COUNT + 1) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  cntStrobe_t        strobe,
  input  logic [1:0]        setSrc,
  input  logic [CNT_W-2:0]  setLiteral,
  input  logic [DATA_W-1:0] dataIn,
  output logic [CNT_W-1:0]  innerCount,
  output logic              countIsZero,
  output logic              countIsInf,
  output logic [DATA_W-1:0] dataOut
);

  localparam logic [CNT_W-1:0] FOREVER = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] MAXV    = CNT_W'(MAX_COUNT);

  logic [CNT_W-1:0] litWide;
  logic [CNT_W-1:0] dataLow;
  logic [CNT_W-1:0] loadValue;

  assign litWide     = {1'b0, setLiteral};
  assign dataLow     = dataIn[CNT_W-1:0];
  assign countIsZero = (innerCount == '0);
  assign countIsInf  = (innerCount == FOREVER);
  assign dataOut     = {dataIn[DATA_W-1:CNT_W], innerCount};

  always_comb begin
    case (countSrc_e'(setSrc))
      SRC_LITERAL: loadValue = (litWide > MAXV) ? MAXV : litWide;
      SRC_FOREVER: loadValue = FOREVER;
      default: begin
        if (dataLow == FOREVER)   loadValue = FOREVER;
        else if (dataLow > MAXV)  loadValue = MAXV;
        else                      loadValue = dataLow;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      innerCount <= '0;
    end else if (strobe.clearCount) begin
      innerCount <= '0;
    end else if (strobe.loadCount) begin
      innerCount <= loadValue;
    end else if (strobe.stepDown && !countIsZero && !countIsInf) begin
      innerCount <= innerCount - 1'b1;
    end
  end

  assert_forever_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    (countIsInf && !strobe.clearCount && !strobe.loadCount) |=> countIsInf);

  assert_step_by_one_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stepDown && !countIsZero && !countIsInf && !strobe.clearCount && !strobe.loadCount)
      |=> (innerCount == $past(innerCount) - CNT_W'(1)));

  assert_clear_wins_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearCount |=> countIsZero);

  assert_count_in_range_R6: assert property (@(posedge clk) disable iff (!rstN)
    (innerCount <= MAXV) || countIsInf);

endmodule

// File: rtl/send_sequencer.sv
module send_sequencer
  import sendseq_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int MAX_COUNT = 12,
  parameter int CNT_W     = $clog2(MAX_COUNT + 1) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [1:0]        instOp,
  input  logic [1:0]        setSrc,
  input  logic [CNT_W-2:0]  setLiteral,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              dataSuccEmpty,
  input  logic              tokenSuccEmpty,
  input  logic              abortReq,
  output logic              fire,
  output logic              done,
  output logic              dataWrite,
  output logic [DATA_W-1:0] dataOut
);

  cntStrobe_t       strobe;
  logic             countIsZero;
  logic             countIsInf;
  logic [CNT_W-1:0] innerCount;

  sendseq_ctrl uCtrl (
    .clk            (clk),
    .rstN           (rstN),
    .instValid      (instValid),
    .instOp         (instOp),
    .dataSuccEmpty  (dataSuccEmpty),
    .tokenSuccEmpty (tokenSuccEmpty),
    .abortReq       (abortReq),
    .countIsZero    (countIsZero),
    .fire           (fire),
    .done           (done),
    .takeWrite      (dataWrite),
    .strobe         (strobe)
  );

  sendseq_dp #(
    .DATA_W    (DATA_W),
    .MAX_COUNT (MAX_COUNT),
    .CNT_W     (CNT_W)
  ) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .setSrc      (setSrc),
    .setLiteral  (setLiteral),
    .dataIn      (dataIn),
    .innerCount  (innerCount),
    .countIsZero (countIsZero),
    .countIsInf  (countIsInf),
    .dataOut     (dataOut)
  );

  assert_fire_needs_slots_R2: assert property (@(posedge clk) disable iff (!rstN)
    fire |-> (instValid && dataSuccEmpty && tokenSuccEmpty));

  assert_forever_never_retires_R4: assert property (@(posedge clk) disable iff (!rstN)
    (countIsInf && fire && !abortReq) |-> !done);

  assert_readout_keeps_upper_R7: assert property (@(posedge clk) disable iff (!rstN)
    dataWrite |-> (dataOut[DATA_W-1:CNT_W] == dataIn[DATA_W-1:CNT_W]));

endmodule

// File: tb/send_sequencer_test.sv
module send_sequencer_test;

  localparam int DATA_W = 16;
  localparam int MAXC   = 12;
  localparam int CW     = 5;
  localparam logic [CW-1:0] INF = 5'd31;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic instValid = 1'b0;
  logic [1:0] instOp = 2'b00;
  logic [1:0] setSrc = 2'b00;
  logic [CW-2:0] setLiteral = '0;
  logic [DATA_W-1:0] dataIn = '0;
  logic dataSuccEmpty = 1'b0;
  logic tokenSuccEmpty = 1'b0;
  logic abortReq = 1'b0;
  logic fire, done, dataWrite;
  logic [DATA_W-1:0] dataOut;

  int checks = 0;
  int failures = 0;
  logic [CW-1:0] model = '0;
  logic lastFire, lastDone;
  logic [DATA_W-1:0] lastOut;

  always #2.5 clk = ~clk;

  send_sequencer #(.DATA_W(DATA_W), .MAX_COUNT(MAXC)) uut (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instOp(instOp),
    .setSrc(setSrc), .setLiteral(setLiteral), .dataIn(dataIn),
    .dataSuccEmpty(dataSuccEmpty), .tokenSuccEmpty(tokenSuccEmpty),
    .abortReq(abortReq), .fire(fire), .done(done),
    .dataWrite(dataWrite), .dataOut(dataOut));

  function automatic logic [CW-1:0] loadFn(input logic [1:0] src,
      input logic [CW-2:0] lit, input logic [DATA_W-1:0] d);
    logic [CW-1:0] low;
    low = d[CW-1:0];
    if (src == 2'b00) return ({1'b0, lit} > CW'(MAXC)) ? CW'(MAXC) : {1'b0, lit};
    if (src == 2'b01) return INF;
    if (low == INF) return INF;
    return (low > CW'(MAXC)) ? CW'(MAXC) : low;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic v, input logic [1:0] op,
      input logic [1:0] src, input logic [CW-2:0] lit, input logic [DATA_W-1:0] d,
      input logic dE, input logic tE, input logic ab);
    logic isSend, eFire, eDone, eWrite;
    @(negedge clk);
    instValid = v; instOp = op; setSrc = src; setLiteral = lit; dataIn = d;
    dataSuccEmpty = dE; tokenSuccEmpty = tE; abortReq = ab;
    #1;
    isSend = v && (op == 2'b01);
    eFire  = isSend && dE && tE;
    eDone  = v && (!isSend || ab || (eFire && model == '0));
    eWrite = v && (op == 2'b11);
    chk(tag, "fire", fire, eFire);
    chk(tag, "done", done, eDone);
    chk(tag, "dataWrite", dataWrite, eWrite);
    if (eWrite) chk(tag, "dataOut", dataOut, {d[DATA_W-1:CW], model});
    lastFire = fire; lastDone = done; lastOut = dataOut;
    if (ab) model = '0;
    else if (v && op == 2'b10) model = loadFn(src, lit, d);
    else if (eFire && model != '0 && model != INF) model = model - 1'b1;
    @(posedge clk);
  endtask

  task automatic setCnt(input string tag, input logic [1:0] src,
                        input logic [CW-2:0] lit, input logic [DATA_W-1:0] d);
    step(tag, 1, 2'b10, src, lit, d, 0, 0, 0);
  endtask

  task automatic readCnt(input string tag, input logic [CW-1:0] expCount);
    step(tag, 1, 2'b11, 0, 0, 16'hA5A0, 0, 0, 0);
    chk(tag, "counter via readout", lastOut[CW-1:0], expCount);
  endtask

  initial begin
    #500us;
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int fires;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    // R1: idle outputs after reset
    step("R1", 0, 2'b01, 0, 0, 0, 1, 1, 0);
    readCnt("R1", 0);
    step("R1", 1, 2'b01, 0, 0, 0, 1, 1, 0);
    chk("R1", "single shot", {lastFire, lastDone}, 2'b11);

    // R3: count 3 gives four firings
    setCnt("R3", 2'b00, 4'd3, 0);
    fires = 0;
    for (int i = 0; i < 20; i++) begin
      step("R3", 1, 2'b01, 0, 0, 0, 1, 1, 0);
      if (lastFire) fires++;
      if (lastDone) break;
    end
    chk("R3", "fire count", fires, 4);

    // R9 + R2: stalled send keeps counter, then completes
    setCnt("R9", 2'b00, 4'd2, 0);
    step("R9", 1, 2'b01, 0, 0, 0, 0, 1, 0);
    step("R2", 1, 2'b01, 0, 0, 0, 1, 0, 0);
    step("R9", 1, 2'b01, 0, 0, 0, 0, 0, 0);
    fires = 0;
    for (int i = 0; i < 20; i++) begin
      step("R9", 1, 2'b01, 0, 0, 0, 1, 1, 0);
      if (lastFire) fires++;
      if (lastDone) break;
    end
    chk("R9", "fires after stall", fires, 3);

    // R6: clamping and sources
    setCnt("R6", 2'b00, 4'd15, 0);  readCnt("R6", 5'd12);
    setCnt("R6", 2'b10, 0, 16'h001F); readCnt("R6", INF);
    setCnt("R6", 2'b11, 0, 16'h0014); readCnt("R6", 5'd12);
    setCnt("R6", 2'b10, 0, 16'hFFE7); readCnt("R6", 5'd7);

    // R8: other opcode leaves counter alone
    step("R8", 1, 2'b00, 0, 0, 0, 1, 1, 0);
    readCnt("R8", 5'd7);

    // R4 then R5: forever, aborted while firing
    setCnt("R4", 2'b01, 0, 0);
    for (int i = 0; i < 15; i++) step("R4", 1, 2'b01, 0, 0, 0, 1, 1, 0);
    readCnt("R4", INF);
    step("R5", 1, 2'b01, 0, 0, 0, 1, 1, 1);
    chk("R5", "abort with fire", {lastFire, lastDone}, 2'b11);
    readCnt("R5", 0);

    // R5: abort on a stalled send, and abort beating a load
    setCnt("R5", 2'b00, 4'd5, 0);
    step("R5", 1, 2'b01, 0, 0, 0, 0, 0, 1);
    chk("R5", "abort stalled", {lastFire, lastDone}, 2'b01);
    step("R5", 1, 2'b10, 2'b00, 4'd9, 0, 0, 0, 1);
    readCnt("R7", 0);

    // randomized mix, every input drawn each cycle
    for (int i = 0; i < 2000; i++) begin
      logic [3:0] r;
      r = 4'($urandom);
      step("R3", ($urandom % 8) != 0, 2'($urandom), 2'($urandom), 4'($urandom),
           16'($urandom), ($urandom % 4) != 0, ($urandom % 4) != 0, r == 4'd0);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule